// File: doc/BRIEF.md
# Three-Mode Interrupt Response Unit

This unit decides, at each instruction boundary of a small 8-bit CPU, whether to accept an interrupt, and how. It takes a level-sensitive maskable request, an edge-sensitive non-maskable request, enable, disable and return-from-NMI commands, a halt indication, a 2-bit mode command, the interrupt page register and the byte the interrupting device places on the data bus. On acceptance it produces, one cycle later, a single-cycle acknowledge with a vector description for the sequencer. The description says whether to push the return address, and whether to jump to a target, fetch a handler address from a vector table, or execute the bus byte as an instruction.

Three vectoring schemes are supported and chosen by the mode register. In mode 0 the bus byte is an instruction: a restart opcode is turned into a direct jump, and anything else is handed back for execution. In mode 1 a fixed restart address is used. In mode 2 a table entry address is formed from the page register and the bus byte. A non-maskable request overrides all of this and goes to its own fixed address. It saves the enable state in a second flip-flop, and a return-from-NMI command restores that state. Acceptance while halted also raises a wake-up pulse, so the sequencer resumes after the halt once the handler returns.

Top module: `irq_resp_unit`

## Requirements
- R1: After reset both enable flags are 0, the mode is 0, and no acknowledge, NMI flag or wake pulse is asserted.
- R2: Without an acceptance in the same cycle: `cmd_retn` copies `iff2` into `iff1`; otherwise `cmd_di` clears both flags; otherwise `cmd_ei` sets both flags. The flags change one cycle after the command.
- R3: A maskable request is accepted only in a cycle where `int_req` is 1, `iff1` is 1 and the CPU is at an acceptance point (`insn_end` or `halted` is 1). A pending NMI wins over a maskable request in the same cycle.
- R4: Accepting a maskable request clears both `iff1` and `iff2`. Acceptance overrides any enable command given in the same cycle.
- R5: A rising edge of `nmi_req` is latched until the next acceptance point, whatever `iff1` is. It is then taken with `ack_nmi`=1, target 0x0066, kind 0 and push 1. It clears `iff1` and leaves `iff2` unchanged. A request held high is taken only once.
- R6: A maskable acceptance in mode 1 gives target 0x0038, kind 0 (jump) and push 1.
- R7: A maskable acceptance in mode 2 gives kind 1 (table) and push 1, with target = {page register, bus byte}.
- R8: A maskable acceptance in mode 0 with a restart opcode on the bus (bits 7:6 = 11, bits 2:0 = 111) gives kind 0, push 1 and target = bits 5:3 of the byte times 8. Any other byte gives kind 2 (execute), push 0 and target 0. Every acceptance copies the bus byte to `exec_op`.
- R9: A mode command with value 0, 1 or 2 loads the mode register. The value 3 is ignored and the mode stays as it was.
- R10: An acceptance while `halted` is 1 raises `halt_wake` together with `ack_valid`. While halted with `iff1` at 0, a maskable request is never accepted.
- R11: The acknowledge outputs appear in the cycle after the acceptance cycle, with `push_pc` equal to `ret_pc` in the acceptance cycle. `ack_valid`, `ack_nmi` and `halt_wake` last one cycle. The vector fields hold until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_req | input | 1 | Maskable interrupt request, level |
| nmi_req | input | 1 | Non-maskable request, rising edge taken |
| insn_end | input | 1 | CPU is at an instruction boundary this cycle |
| halted | input | 1 | CPU is in the halt state |
| cmd_ei | input | 1 | Enable command |
| cmd_di | input | 1 | Disable command |
| cmd_retn | input | 1 | Return-from-NMI command |
| cmd_mode_ld | input | 1 | Load the mode register |
| cmd_mode_val | input | 2 | Mode value to load |
| i_reg | input | 8 | Interrupt page register |
| bus_data | input | 8 | Byte supplied by the interrupting device |
| ret_pc | input | 16 | Return address to push |
| ack_valid | output | 1 | Interrupt accepted (one cycle) |
| ack_nmi | output | 1 | Accepted interrupt was non-maskable |
| ack_kind | output | 2 | 0 jump, 1 table fetch, 2 execute bus byte |
| ack_push | output | 1 | Push return address |
| target_addr | output | 16 | Jump target or table entry address |
| exec_op | output | 8 | Bus byte captured at acceptance |
| push_pc | output | 16 | Return address captured at acceptance |
| halt_wake | output | 1 | Acceptance ended a halt |
| iff1 | output | 1 | Maskable enable flag |
| iff2 | output | 1 | Saved copy of the enable flag |
| im_mode | output | 2 | Current vectoring mode |

## Verification
The assertions take for granted that the CPU gives `int_req`, `i_reg`, `bus_data` and `ret_pc` valid values in every cycle where an acceptance point is signalled. They also assume commands are single-cycle levels sampled at the clock edge. Stimulus changes only midway between edges and always presents complete values. Directed sequences cover each mode, halting with the flag clear, an NMI held high, and simultaneous requests. A long stretch of random cycles then mixes commands, requests and acceptance points, and a behavioural model checks every output on every clock.

// File: rtl/irq_resp_pkg.sv
package irq_resp_pkg;
   typedef enum logic [1:0] {
      VK_JUMP  = 2'd0,
      VK_TABLE = 2'd1,
      VK_EXEC  = 2'd2
   } vec_kind_t;

   localparam logic [1:0] MODE_RESERVED = 2'b11;
endpackage

// File: rtl/irq_flag_ctl.sv
module irq_flag_ctl #(
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_mask,
   input  logic              take_nmi,
   input  logic              cmd_ei,
   input  logic              cmd_di,
   input  logic              cmd_retn,
   input  logic              cmd_mode_ld,
   input  logic [MODE_W-1:0] cmd_mode_val,
   output logic              iff1,
   output logic              iff2,
   output logic [MODE_W-1:0] mode
);
   import irq_resp_pkg::*;

   localparam logic [MODE_W-1:0] MODE_RST = '0;

   // Acceptance wins over commands; among commands retn > di > ei.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iff1 <= 1'b0;
         iff2 <= 1'b0;
      end else if (take_nmi) begin
         iff1 <= 1'b0;
      end else if (take_mask) begin
         iff1 <= 1'b0;
         iff2 <= 1'b0;
      end else if (cmd_retn) begin
         iff1 <= iff2;
      end else if (cmd_di) begin
         iff1 <= 1'b0;
         iff2 <= 1'b0;
      end else if (cmd_ei) begin
         iff1 <= 1'b1;
         iff2 <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode <= MODE_RST;
      else if (cmd_mode_ld && (cmd_mode_val != MODE_RESERVED))
         mode <= cmd_mode_val;
   end
endmodule

// File: rtl/irq_accept.sv
module irq_accept (
   input  logic clk,
   input  logic rst_n,
   input  logic int_req,
   input  logic nmi_req,
   input  logic insn_end,
   input  logic halted,
   input  logic iff1,
   output logic take_nmi,
   output logic take_mask
);
   logic nmi_q;
   logic nmi_pend;
   logic pend_now;
   logic at_point;

   assign at_point  = insn_end | halted;
   assign pend_now  = nmi_pend | (nmi_req & ~nmi_q);
   assign take_nmi  = pend_now & at_point;
   assign take_mask = ~take_nmi & int_req & iff1 & at_point;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_q    <= 1'b0;
         nmi_pend <= 1'b0;
      end else begin
         nmi_q    <= nmi_req;
         nmi_pend <= pend_now & ~take_nmi;
      end
   end
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen #(
   parameter int              ADDR_W     = 16,
   parameter int              VEC_W      = 8,
   parameter logic [15:0]     FIXED_TGT  = 16'h0038,
   parameter logic [15:0]     NMI_TGT    = 16'h0066,
   parameter bit              TABLE_EVEN = 1'b0
) (
   input  logic                    take_nmi,
   input  logic [1:0]              mode,
   input  logic [VEC_W-1:0]        page,
   input  logic [VEC_W-1:0]        vec_byte,
   output logic [ADDR_W-1:0]       tgt,
   output irq_resp_pkg::vec_kind_t kind,
   output logic                    push
);
   import irq_resp_pkg::*;

   localparam int RST_IDX_W = 3;
   localparam int RST_SHIFT = 3;

   logic [ADDR_W-1:0] table_addr;
   logic [ADDR_W-1:0] rst_addr;
   logic              is_rst;

   assign is_rst   = (vec_byte[7:6] == 2'b11) && (vec_byte[2:0] == 3'b111);
   assign rst_addr = ADDR_W'(vec_byte[RST_SHIFT +: RST_IDX_W]) << RST_SHIFT;

   generate
      if (TABLE_EVEN) begin : g_tbl_even
         assign table_addr = ADDR_W'({page, vec_byte[VEC_W-1:1], 1'b0});
      end else begin : g_tbl_any
         assign table_addr = ADDR_W'({page, vec_byte});
      end
   endgenerate

   always_comb begin
      tgt  = '0;
      kind = VK_JUMP;
      push = 1'b1;
      if (take_nmi) begin
         tgt = ADDR_W'(NMI_TGT);
      end else begin
         case (mode)
            2'd1: tgt = ADDR_W'(FIXED_TGT);
            2'd2: begin
               tgt  = table_addr;
               kind = VK_TABLE;
            end
            default: begin
               if (is_rst) begin
                  tgt = rst_addr;
               end else begin
                  kind = VK_EXEC;
                  push = 1'b0;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/irq_resp_unit.sv
module irq_resp_unit #(
   parameter int          ADDR_W     = 16,
   parameter int          VEC_W      = 8,
   parameter logic [15:0] FIXED_TGT  = 16'h0038,
   parameter logic [15:0] NMI_TGT    = 16'h0066,
   parameter bit          TABLE_EVEN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              int_req,
   input  logic              nmi_req,
   input  logic              insn_end,
   input  logic              halted,
   input  logic              cmd_ei,
   input  logic              cmd_di,
   input  logic              cmd_retn,
   input  logic              cmd_mode_ld,
   input  logic [1:0]        cmd_mode_val,
   input  logic [VEC_W-1:0]  i_reg,
   input  logic [VEC_W-1:0]  bus_data,
   input  logic [ADDR_W-1:0] ret_pc,
   output logic              ack_valid,
   output logic              ack_nmi,
   output logic [1:0]        ack_kind,
   output logic              ack_push,
   output logic [ADDR_W-1:0] target_addr,
   output logic [VEC_W-1:0]  exec_op,
   output logic [ADDR_W-1:0] push_pc,
   output logic              halt_wake,
   output logic              iff1,
   output logic              iff2,
   output logic [1:0]        im_mode
);
   import irq_resp_pkg::*;

   generate
      if (ADDR_W < 16) begin : g_bad_addr
         $error("irq_resp_unit: ADDR_W must be at least 16");
      end
      if (VEC_W != 8) begin : g_bad_vec
         $error("irq_resp_unit: VEC_W must be 8");
      end
   endgenerate

   logic              take_nmi;
   logic              take_mask;
   logic              take_any;
   logic [ADDR_W-1:0] vg_tgt;
   vec_kind_t         vg_kind;
   logic              vg_push;

   assign take_any = take_nmi | take_mask;

   irq_accept u_accept (
      .clk       (clk),
      .rst_n     (rst_n),
      .int_req   (int_req),
      .nmi_req   (nmi_req),
      .insn_end  (insn_end),
      .halted    (halted),
      .iff1      (iff1),
      .take_nmi  (take_nmi),
      .take_mask (take_mask)
   );

   irq_flag_ctl #(.MODE_W(2)) u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .take_mask    (take_mask),
      .take_nmi     (take_nmi),
      .cmd_ei       (cmd_ei),
      .cmd_di       (cmd_di),
      .cmd_retn     (cmd_retn),
      .cmd_mode_ld  (cmd_mode_ld),
      .cmd_mode_val (cmd_mode_val),
      .iff1         (iff1),
      .iff2         (iff2),
      .mode         (im_mode)
   );

   irq_vector_gen #(
      .ADDR_W     (ADDR_W),
      .VEC_W      (VEC_W),
      .FIXED_TGT  (FIXED_TGT),
      .NMI_TGT    (NMI_TGT),
      .TABLE_EVEN (TABLE_EVEN)
   ) u_vec (
      .take_nmi (take_nmi),
      .mode     (im_mode),
      .page     (i_reg),
      .vec_byte (bus_data),
      .tgt      (vg_tgt),
      .kind     (vg_kind),
      .push     (vg_push)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_valid   <= 1'b0;
         ack_nmi     <= 1'b0;
         halt_wake   <= 1'b0;
         ack_kind    <= VK_JUMP;
         ack_push    <= 1'b0;
         target_addr <= '0;
         exec_op     <= '0;
         push_pc     <= '0;
      end else begin
         ack_valid <= take_any;
         ack_nmi   <= take_nmi;
         halt_wake <= take_any & halted;
         if (take_any) begin
            ack_kind    <= vg_kind;
            ack_push    <= vg_push;
            target_addr <= vg_tgt;
            exec_op     <= bus_data;
            push_pc     <= ret_pc;
         end
      end
   end
endmodule

// File: rtl/irq_resp_chk.sv
module irq_resp_chk #(
   parameter int          ADDR_W    = 16,
   parameter logic [15:0] FIXED_TGT = 16'h0038,
   parameter logic [15:0] NMI_TGT   = 16'h0066
) (
   input logic              clk,
   input logic              rst_n,
   input logic              int_req,
   input logic              insn_end,
   input logic              halted,
   input logic              ack_valid,
   input logic              ack_nmi,
   input logic [1:0]        ack_kind,
   input logic              ack_push,
   input logic [ADDR_W-1:0] target_addr,
   input logic              halt_wake,
   input logic              iff1,
   input logic              iff2,
   input logic [1:0]        im_mode
);
   a_r3_mask_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && !ack_nmi) |-> ($past(iff1) && $past(int_req)));

   a_r4_mask_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && !ack_nmi) |-> (!iff1 && !iff2));

   a_r5_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
      ack_nmi |-> (ack_valid && target_addr == ADDR_W'(NMI_TGT) && !iff1 && iff2 == $past(iff2)));

   a_r6_fixed_target: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && !ack_nmi && $past(im_mode) == 2'd1) |-> (target_addr == ADDR_W'(FIXED_TGT) && ack_push));

   a_r8_exec_no_push: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_kind == 2'd2) |-> !ack_push);

   a_r9_no_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
      im_mode != 2'b11);

   a_r10_wake_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
      halt_wake |-> (ack_valid && $past(halted)));

   a_r11_ack_at_point: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> ($past(insn_end) || $past(halted)));

   a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && !ack_nmi) |=> !(ack_valid && !ack_nmi));
endmodule

bind irq_resp_unit irq_resp_chk #(
   .ADDR_W    (ADDR_W),
   .FIXED_TGT (FIXED_TGT),
   .NMI_TGT   (NMI_TGT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .int_req     (int_req),
   .insn_end    (insn_end),
   .halted      (halted),
   .ack_valid   (ack_valid),
   .ack_nmi     (ack_nmi),
   .ack_kind    (ack_kind),
   .ack_push    (ack_push),
   .target_addr (target_addr),
   .halt_wake   (halt_wake),
   .iff1        (iff1),
   .iff2        (iff2),
   .im_mode     (im_mode)
);

// File: tb/tb_irq_resp_unit.sv
module tb_irq_resp_unit;
   localparam int PER = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        int_req = 1'b0, nmi_req = 1'b0, insn_end = 1'b0, halted = 1'b0;
   logic        cmd_ei = 1'b0, cmd_di = 1'b0, cmd_retn = 1'b0, cmd_mode_ld = 1'b0;
   logic [1:0]  cmd_mode_val = 2'd0;
   logic [7:0]  i_reg = 8'd0, bus_data = 8'd0;
   logic [15:0] ret_pc = 16'd0;
   logic        ack_valid, ack_nmi, ack_push, halt_wake, iff1, iff2;
   logic [1:0]  ack_kind, im_mode;
   logic [15:0] target_addr, push_pc;
   logic [7:0]  exec_op;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   irq_resp_unit dut (
      .clk(clk), .rst_n(rst_n), .int_req(int_req), .nmi_req(nmi_req),
      .insn_end(insn_end), .halted(halted), .cmd_ei(cmd_ei), .cmd_di(cmd_di),
      .cmd_retn(cmd_retn), .cmd_mode_ld(cmd_mode_ld), .cmd_mode_val(cmd_mode_val),
      .i_reg(i_reg), .bus_data(bus_data), .ret_pc(ret_pc),
      .ack_valid(ack_valid), .ack_nmi(ack_nmi), .ack_kind(ack_kind),
      .ack_push(ack_push), .target_addr(target_addr), .exec_op(exec_op),
      .push_pc(push_pc), .halt_wake(halt_wake), .iff1(iff1), .iff2(iff2),
      .im_mode(im_mode)
   );

   always #(PER/2) clk = ~clk;

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference state
   bit          m_iff1, m_iff2, m_nq, m_pend;
   bit   [1:0]  m_mode;
   bit          e_ack, e_nmi, e_wake, e_push;
   bit   [1:0]  e_kind;
   bit   [15:0] e_tgt, e_pc;
   bit   [7:0]  e_op;
   bit          pt, pend, tn, tm;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_iff1 = 0; m_iff2 = 0; m_nq = 0; m_pend = 0; m_mode = 0;
         e_ack = 0; e_nmi = 0; e_wake = 0; e_push = 0; e_kind = 0;
         e_tgt = 0; e_pc = 0; e_op = 0;
      end else begin
         pt   = insn_end || halted;
         pend = m_pend || (nmi_req && !m_nq);
         tn   = pend && pt;
         tm   = !tn && int_req && m_iff1 && pt;
         m_nq = nmi_req;
         m_pend = pend && !tn;
         e_ack  = tn || tm;
         e_nmi  = tn;
         e_wake = (tn || tm) && halted;
         if (tn || tm) begin
            e_pc = ret_pc;
            e_op = bus_data;
            e_push = 1;
            e_kind = 0;
            if (tn) e_tgt = 16'h0066;
            else if (m_mode == 1) e_tgt = 16'h0038;
            else if (m_mode == 2) begin e_tgt = {i_reg, bus_data}; e_kind = 1; end
            else if (bus_data[7:6] == 2'b11 && bus_data[2:0] == 3'b111)
               e_tgt = 16'(bus_data[5:3]) * 16'd8;
            else begin e_tgt = 0; e_kind = 2; e_push = 0; end
         end
         if (tn) m_iff1 = 0;
         else if (tm) begin m_iff1 = 0; m_iff2 = 0; end
         else if (cmd_retn) m_iff1 = m_iff2;
         else if (cmd_di) begin m_iff1 = 0; m_iff2 = 0; end
         else if (cmd_ei) begin m_iff1 = 1; m_iff2 = 1; end
         if (cmd_mode_ld && cmd_mode_val != 2'b11) m_mode = cmd_mode_val;
      end
      #(PER/4);
      chk("R2 iff1", 16'(iff1), 16'(m_iff1));
      chk("R2 iff2", 16'(iff2), 16'(m_iff2));
      chk("R9 mode", 16'(im_mode), 16'(m_mode));
      chk("R3 ack_valid", 16'(ack_valid), 16'(e_ack));
      chk("R5 ack_nmi", 16'(ack_nmi), 16'(e_nmi));
      chk("R10 halt_wake", 16'(halt_wake), 16'(e_wake));
      chk("R7 ack_kind", 16'(ack_kind), 16'(e_kind));
      chk("R8 ack_push", 16'(ack_push), 16'(e_push));
      chk("R6 target", target_addr, e_tgt);
      chk("R8 exec_op", 16'(exec_op), 16'(e_op));
      chk("R11 push_pc", push_pc, e_pc);
   end

   // Apply current inputs at the next edge; return mid-cycle with results visible.
   task automatic go();
      @(posedge clk);
      #(PER/2 - 1);
   endtask

   task automatic pulse_ei();
      cmd_ei = 1; go(); cmd_ei = 0;
   endtask

   task automatic load_mode(input logic [1:0] v);
      cmd_mode_ld = 1; cmd_mode_val = v; go(); cmd_mode_ld = 0;
   endtask

   initial begin
      #(PER*100000);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      #(PER/2 - 1);
      go(); go(); go();
      chk("R1 iff1", 16'(iff1), 16'd0);
      chk("R1 iff2", 16'(iff2), 16'd0);
      chk("R1 mode", 16'(im_mode), 16'd0);
      chk("R1 ack", 16'({ack_valid, ack_nmi, halt_wake}), 16'd0);
      rst_n = 1; go();

      // R3: request ignored while disabled
      int_req = 1; insn_end = 1; go(); go();
      chk("R3 disabled no ack", 16'(ack_valid), 16'd0);
      int_req = 0;

      // R2: enable then disable
      pulse_ei();
      chk("R2 ei iff1", 16'(iff1), 16'd1);
      chk("R2 ei iff2", 16'(iff2), 16'd1);
      cmd_di = 1; go(); cmd_di = 0;
      chk("R2 di iff1", 16'(iff1), 16'd0);
      chk("R2 di iff2", 16'(iff2), 16'd0);

      // R6 / R4 / R11: mode 1 fixed restart
      load_mode(2'd1);
      chk("R9 mode load 1", 16'(im_mode), 16'd1);
      pulse_ei();
      ret_pc = 16'h1234; int_req = 1; go();
      chk("R6 ack", 16'(ack_valid), 16'd1);
      chk("R6 target", target_addr, 16'h0038);
      chk("R6 kind/push", 16'({ack_kind, ack_push}), 16'b001);
      chk("R11 push_pc", push_pc, 16'h1234);
      chk("R4 flags cleared", 16'({iff1, iff2}), 16'd0);
      int_req = 0; go();
      chk("R11 one-cycle ack", 16'(ack_valid), 16'd0);
      chk("R11 target held", target_addr, 16'h0038);

      // R3: no acceptance away from an acceptance point
      pulse_ei();
      insn_end = 0; int_req = 1; go(); go();
      chk("R3 no point no ack", 16'(ack_valid), 16'd0);
      int_req = 0; insn_end = 1;

      // R9: reserved value ignored
      load_mode(2'd3);
      chk("R9 reserved ignored", 16'(im_mode), 16'd1);
      load_mode(2'd2);
      chk("R9 mode load 2", 16'(im_mode), 16'd2);

      // R7: table address
      i_reg = 8'h5A; bus_data = 8'hC4; int_req = 1; go();
      chk("R7 ack", 16'(ack_valid), 16'd1);
      chk("R7 target", target_addr, 16'h5AC4);
      chk("R7 kind/push", 16'({ack_kind, ack_push}), 16'b011);
      int_req = 0;

      // R8: mode 0 restart and execute
      load_mode(2'd0);
      pulse_ei();
      bus_data = 8'hDF; int_req = 1; go();
      chk("R8 restart target", target_addr, 16'h0018);
      chk("R8 restart kind/push", 16'({ack_kind, ack_push}), 16'b001);
      int_req = 0;
      pulse_ei();
      bus_data = 8'h3E; int_req = 1; go();
      chk("R8 exec kind/push", 16'({ack_kind, ack_push}), 16'b100);
      chk("R8 exec_op", 16'(exec_op), 16'h003E);
      chk("R8 exec target", target_addr, 16'h0000);
      int_req = 0;

      // R5: NMI latched, taken at point, once, restore via retn
      pulse_ei();
      insn_end = 0; nmi_req = 1; go();
      chk("R5 nmi waits for point", 16'(ack_valid), 16'd0);
      go();
      insn_end = 1; go();
      chk("R5 nmi ack", 16'({ack_valid, ack_nmi}), 16'b11);
      chk("R5 nmi target", target_addr, 16'h0066);
      chk("R5 nmi flags", 16'({iff1, iff2}), 16'b01);
      go();
      chk("R5 held nmi once", 16'(ack_valid), 16'd0);
      nmi_req = 0;
      cmd_retn = 1; go(); cmd_retn = 0;
      chk("R2 retn restores", 16'(iff1), 16'd1);

      // R3: NMI beats maskable in the same cycle
      int_req = 1; nmi_req = 1; go();
      chk("R3 nmi priority", 16'(ack_nmi), 16'd1);
      go();
      chk("R3 masked after nmi", 16'(ack_valid), 16'd0);
      int_req = 0; nmi_req = 0;

      // R10: halt with flag clear never ends; enable then wake
      insn_end = 0; halted = 1; int_req = 1; go(); go(); go();
      chk("R10 halt stuck", 16'(ack_valid), 16'd0);
      pulse_ei();
      chk("R10 no ack on ei edge", 16'(ack_valid), 16'd0);
      go();
      chk("R10 wake", 16'({ack_valid, halt_wake}), 16'b11);
      halted = 0; int_req = 0; go();
      chk("R10 wake pulse", 16'(halt_wake), 16'd0);

      // Random mix, checked against the model every clock
      for (int i = 0; i < 3000; i++) begin
         r = $urandom;
         int_req      = (r[1:0] == 2'd0);
         nmi_req      = (r[5:2] == 4'd0) ? ~nmi_req : nmi_req;
         insn_end     = r[6];
         halted       = (r[9:7] == 3'd0);
         cmd_ei       = (r[12:10] == 3'd0);
         cmd_di       = (r[16:13] == 4'd0);
         cmd_retn     = (r[20:17] == 4'd0);
         cmd_mode_ld  = (r[23:21] == 3'd0);
         cmd_mode_val = r[25:24];
         r = $urandom;
         i_reg    = r[7:0];
         bus_data = r[15:8];
         ret_pc   = r[31:16];
         go();
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule